// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Core

This block is a small processor with one working register, the accumulator. Program and data live in one synchronous RAM. Each instruction passes through three phases of one clock each. First the word at the program counter is fetched. Next it is latched into the instruction register while the RAM reads the location named by the operand. Last the instruction is executed. The core runs the instruction set load, add, subtract, store, jump and halt. It stops in a halted state that only reset leaves.

A per-instruction mode bit picks the right-hand ALU value. With the bit clear, the value is the RAM word at the operand address. With the bit set, the value is the operand itself, used as an immediate. Load is carried out as an addition onto zero. The bench loads the RAM through a dedicated preload port while the core is held in reset. The same port reads words back afterwards.

Top module: `acc_cpu_core`

## Requirements
- R1: While and right after reset, the program counter is 0, the accumulator is 0 and `halted` is 0. Execution begins at address 0.
- R2: An instruction word is 10 bits: opcode in [9:7], mode in [6], operand in [5:0]. Opcodes are 000 halt, 001 load, 010 add, 011 sub, 100 store and 101 jump. The codes 110 and 111 behave as halt.
- R3: With mode 0 the ALU value is the RAM word at the operand address. With mode 1 it is the 6-bit operand, zero-extended.
- R4: Load places 0 plus the selected value in the accumulator.
- R5: Add places the accumulator plus the selected value in the accumulator, modulo 1024.
- R6: Sub places the accumulator minus the selected value in the accumulator, modulo 1024.
- R7: Store writes the accumulator to the RAM word at the operand address whatever the mode bit is. The accumulator is unchanged.
- R8: Jump loads the operand into the program counter.
- R9: Every instruction other than jump and halt advances the program counter by one, and 63 wraps to 0.
- R10: A halt sets `halted`. From then on the accumulator, program counter and RAM contents stay frozen until reset.
- R11: Each instruction takes exactly three clock cycles. The accumulator and `halted` change on the clock edge that ends the execute phase.
- R12: A preload write stores `pl_wdata` at `pl_addr` on the clock edge. `pl_rdata` shows the word at `pl_addr` one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | 6 | Preload address |
| pl_wdata | input | 10 | Preload write data |
| pl_rdata | output | 10 | Registered preload read data |
| halted | output | 1 | High once a halt has executed |
| acc_out | output | 10 | Accumulator value |

## Verification
The bench runs four programs, each checked cycle by cycle against a behavioural model.

- **Memory-operand sum.** A load/add/store program separates correct operand sourcing from phase timing.
- **Mixed modes.** Immediate and memory operands are interleaved with subtraction below zero, a mode-1 store, a jump over a poisoned word and an unused opcode. This separates the two mode paths and both wrap-arounds.
- **Self-modifying wrap.** A program rewrites address 0 and runs off the top of memory, which exposes the counter wrap.
- **Halt on an unused code.** A final program halts on opcode 111 with live code after it, which shows the core stays frozen.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [2:0] {
    OP_HALT  = 3'b000,
    OP_LOAD  = 3'b001,
    OP_ADD   = 3'b010,
    OP_SUB   = 3'b011,
    OP_STORE = 3'b100,
    OP_JUMP  = 3'b101
  } opcode_e;

  typedef enum logic {
    ALU_ADD = 1'b0,
    ALU_SUB = 1'b1
  } alu_op_e;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_HALT   = 2'd3
  } phase_e;

  typedef struct packed {
    alu_op_e alu_op;
    logic    zero_left;
    logic    use_imm;
    logic    acc_we;
    logic    mem_we;
    logic    pc_load;
    logic    stop;
  } ctrl_t;

endpackage

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic              core_we,
  input  logic [DATA_W-1:0] core_wdata,
  output logic [DATA_W-1:0] core_rdata,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic              pl_we,
  input  logic [DATA_W-1:0] pl_wdata,
  output logic [DATA_W-1:0] pl_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // read-first on both ports; the preload port wins a write collision
  always_ff @(posedge clk) begin
    core_rdata <= mem_q[core_addr];
    pl_rdata   <= mem_q[pl_addr];
    if (pl_we) begin
      mem_q[pl_addr] <= pl_wdata;
    end else if (core_we) begin
      mem_q[core_addr] <= core_wdata;
    end
  end

endmodule

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  logic [2:0] opcode_i,
  input  logic       mode_i,
  output ctrl_t      ctrl_o
);

  always_comb begin
    ctrl_o           = '0;
    ctrl_o.alu_op    = ALU_ADD;
    ctrl_o.use_imm   = mode_i;
    case (opcode_e'(opcode_i))
      OP_LOAD: begin
        ctrl_o.zero_left = 1'b1;
        ctrl_o.acc_we    = 1'b1;
      end
      OP_ADD: begin
        ctrl_o.acc_we    = 1'b1;
      end
      OP_SUB: begin
        ctrl_o.alu_op    = ALU_SUB;
        ctrl_o.acc_we    = 1'b1;
      end
      OP_STORE: begin
        ctrl_o.use_imm   = 1'b0;
        ctrl_o.mem_we    = 1'b1;
      end
      OP_JUMP: begin
        ctrl_o.use_imm   = 1'b0;
        ctrl_o.pc_load   = 1'b1;
      end
      default: begin
        // halt and both spare codes
        ctrl_o.use_imm   = 1'b0;
        ctrl_o.stop      = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 10
) (
  input  alu_op_e      op_i,
  input  logic         zero_left_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] res_o
);

  function automatic logic [W-1:0] add_sub(alu_op_e op, logic [W-1:0] a,
                                           logic [W-1:0] b);
    logic [W-1:0] r;
    if (op == ALU_SUB) r = a - b;
    else               r = a + b;
    return r;
  endfunction

  logic [W-1:0] left;

  always_comb begin
    left  = zero_left_i ? '0 : acc_i;
    res_o = add_sub(op_i, left, val_i);
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pl_we,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [WORD_W-1:0] pl_wdata,
  output logic [WORD_W-1:0] pl_rdata,
  output logic              halted,
  output logic [WORD_W-1:0] acc_out
);
  localparam int OPC_W   = 3;
  localparam int OP_LSB  = WORD_W - OPC_W;
  localparam int MODE_B  = ADDR_W;
  localparam int EXT_W   = WORD_W - ADDR_W;

  phase_e            state_q, state_d;
  logic [ADDR_W-1:0] pc_q;
  logic [WORD_W-1:0] ir_q;
  logic [WORD_W-1:0] acc_q;

  logic [ADDR_W-1:0] ram_addr;
  logic [WORD_W-1:0] ram_rdata;
  logic [OPC_W-1:0]  ir_opcode;
  logic              ir_mode;
  logic [ADDR_W-1:0] ir_operand;
  ctrl_t             ctrl;
  logic [WORD_W-1:0] operand_val;
  logic [WORD_W-1:0] alu_res;

  // named internal events
  logic exec_fire;
  logic acc_we_evt;
  logic mem_we_evt;
  logic jump_evt;
  logic halt_evt;

  assign ir_opcode  = ir_q[WORD_W-1:OP_LSB];
  assign ir_mode    = ir_q[MODE_B];
  assign ir_operand = ir_q[ADDR_W-1:0];

  assign exec_fire  = (state_q == ST_EXEC);
  assign acc_we_evt = exec_fire && ctrl.acc_we;
  assign mem_we_evt = exec_fire && ctrl.mem_we;
  assign jump_evt   = exec_fire && ctrl.pc_load;
  assign halt_evt   = exec_fire && ctrl.stop;

  acc_cpu_decode u_dec (
    .opcode_i (ir_opcode),
    .mode_i   (ir_mode),
    .ctrl_o   (ctrl)
  );

  // operand multiplexer: immediate or memory word
  assign operand_val = ctrl.use_imm ? {{EXT_W{1'b0}}, ir_operand} : ram_rdata;

  acc_cpu_alu #(.W(WORD_W)) u_alu (
    .op_i        (ctrl.alu_op),
    .zero_left_i (ctrl.zero_left),
    .acc_i       (acc_q),
    .val_i       (operand_val),
    .res_o       (alu_res)
  );

  // RAM address selection per phase
  always_comb begin
    case (state_q)
      ST_FETCH:  ram_addr = pc_q;
      ST_DECODE: ram_addr = ram_rdata[ADDR_W-1:0];
      ST_EXEC:   ram_addr = ir_operand;
      default:   ram_addr = pc_q;
    endcase
  end

  acc_cpu_ram #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_ram (
    .clk        (clk),
    .core_addr  (ram_addr),
    .core_we    (mem_we_evt),
    .core_wdata (acc_q),
    .core_rdata (ram_rdata),
    .pl_addr    (pl_addr),
    .pl_we      (pl_we),
    .pl_wdata   (pl_wdata),
    .pl_rdata   (pl_rdata)
  );

  always_comb begin
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC:   state_d = ctrl.stop ? ST_HALT : ST_FETCH;
      default:   state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DECODE) ir_q <= ram_rdata;
      if (acc_we_evt) acc_q <= alu_res;
      if (jump_evt) begin
        pc_q <= ir_operand;
      end else if (exec_fire && !ctrl.stop) begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end

  assign halted  = (state_q == ST_HALT);
  assign acc_out = acc_q;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && !jump_evt && !halt_evt) |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1))); // R9
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    jump_evt |=> (pc_q == $past(ir_operand))); // R8
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(acc_q) && $stable(pc_q))); // R10
  AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_evt |=> $stable(acc_q)); // R7
  AST_ONE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_we_evt, mem_we_evt, jump_evt, halt_evt})); // R2
  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) |=> (state_q == ST_DECODE)); // R11
  AST_EXEC_AFTER_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECODE) |=> exec_fire); // R11

endmodule

// File: tb/acc_cpu_core_tb.sv
`timescale 1ns/1ps
module acc_cpu_core_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pl_we = 1'b0;
  logic [5:0] pl_addr = '0;
  logic [9:0] pl_wdata = '0;
  logic [9:0] pl_rdata;
  logic       halted;
  logic [9:0] acc_out;

  always #2.5 clk = ~clk;

  acc_cpu_core dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pl_we    (pl_we),
    .pl_addr  (pl_addr),
    .pl_wdata (pl_wdata),
    .pl_rdata (pl_rdata),
    .halted   (halted),
    .acc_out  (acc_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  int total_cyc = 0;
  bit cmp_on = 1'b0;

  int img [64];
  int m_mem [64];
  int m_pc, m_acc, m_ir, m_opv, m_ph;
  bit m_halt;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int enc(int op, int mode, int opnd);
    return (op << 7) | (mode << 6) | (opnd & 63);
  endfunction

  // behavioural reference: one step per clock edge
  always @(posedge clk) begin
    int op, mode, opn, val;
    if (!rst_n) begin
      m_pc = 0; m_acc = 0; m_halt = 0; m_ph = 0;
    end else if (!m_halt) begin
      if (m_ph == 0) begin
        m_ir = m_mem[m_pc]; m_ph = 1;
      end else if (m_ph == 1) begin
        m_opv = m_mem[m_ir & 63]; m_ph = 2;
      end else begin
        op = m_ir >> 7; mode = (m_ir >> 6) & 1; opn = m_ir & 63;
        val = mode ? opn : m_opv;
        m_ph = 0;
        case (op)
          1: begin m_acc = val; m_pc = (m_pc + 1) % 64; end
          2: begin m_acc = (m_acc + val) % 1024; m_pc = (m_pc + 1) % 64; end
          3: begin m_acc = (m_acc - val + 1024) % 1024; m_pc = (m_pc + 1) % 64; end
          4: begin m_mem[opn] = m_acc; m_pc = (m_pc + 1) % 64; end
          5: m_pc = opn;
          default: m_halt = 1;
        endcase
      end
    end
    if (pl_we) m_mem[pl_addr] = pl_wdata;
  end

  // per-cycle comparison away from the active edge (R11)
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R11 acc", acc_out, m_acc);
      check("R11 halted", halted, m_halt);
    end
  end

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", total_cyc, 150000);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic clear_img();
    for (int i = 0; i < 64; i++) img[i] = 0;
  endtask

  // hold reset, preload every word, release; returns cycles until halt
  task automatic run_prog(int limit, output int cycles);
    cmp_on = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      pl_we = 1'b1; pl_addr = 6'(i); pl_wdata = 10'(img[i]);
    end
    @(negedge clk); pl_we = 1'b0;
    check("R1 acc in reset", acc_out, 0);
    check("R1 halted in reset", halted, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    cycles = 0;
    while (!halted && cycles < limit) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic read_loc(int addr, int exp, string req);
    @(negedge clk); pl_addr = 6'(addr);
    @(negedge clk);
    check(req, pl_rdata, exp);
  endtask

  initial begin
    int cyc;

    // program 1: memory-operand sum
    clear_img();
    img[0] = enc(1, 0, 13); img[1] = enc(2, 0, 14);
    img[2] = enc(4, 0, 15); img[3] = enc(0, 0, 0);
    img[13] = 100; img[14] = 250;
    run_prog(400, cyc);
    check("R1 R11 cycles to halt", cyc, 12);
    check("R4 R5 acc", acc_out, 350);
    check("R10 halted", halted, 1);
    read_loc(15, 350, "R7 store result");
    read_loc(13, 100, "R12 preload readback");

    // program 2: mixed modes, wrap, jump, spare opcode
    clear_img();
    img[0] = enc(1, 1, 5);   img[1] = enc(3, 1, 9);
    img[2] = enc(2, 0, 30);  img[3] = enc(4, 1, 31);
    img[4] = enc(5, 0, 6);   img[5] = enc(1, 1, 63);
    img[6] = enc(3, 0, 32);  img[7] = enc(4, 0, 33);
    img[8] = enc(6, 0, 0);   img[9] = enc(2, 1, 1);
    img[30] = 7; img[32] = 4;
    run_prog(400, cyc);
    check("R6 R8 R2 acc", acc_out, 1023);
    check("R2 halt on 110", halted, 1);
    read_loc(31, 3, "R3 R6 R7 mode-1 store");
    read_loc(33, 1023, "R6 sub wrap");
    read_loc(5, enc(1, 1, 63), "R12 untouched word");

    // program 3: self-modify address 0 and wrap the counter
    clear_img();
    img[0] = enc(5, 0, 61);  img[61] = enc(1, 1, 0);
    img[62] = enc(4, 0, 0);  img[63] = enc(1, 1, 9);
    run_prog(400, cyc);
    check("R9 acc after wrap", acc_out, 9);
    check("R9 halted after wrap", halted, 1);
    check("R9 cycles", cyc, 15);
    read_loc(0, 0, "R7 R9 rewritten word");

    // program 4: halt on 111 then stay frozen
    clear_img();
    img[0] = enc(1, 1, 3); img[1] = enc(7, 1, 20);
    img[2] = enc(2, 1, 1); img[3] = enc(4, 0, 40);
    img[40] = 55;
    run_prog(400, cyc);
    repeat (20) @(negedge clk);
    check("R10 R2 acc frozen", acc_out, 3);
    check("R10 still halted", halted, 1);
    read_loc(40, 55, "R10 memory frozen");

    cmp_on = 1'b0;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule